// File: doc/BRIEF.md
# Sector Read Pulse Stream Generator

This block synthesises the self-clocked pulse train that a disk read head would deliver for one sector at a time. Every bit cell carries a clock pulse in its first half. A one bit adds a second pulse in the second half. The pulse line is active low and idles high. Each sector starts at the falling edge of the sector mark and has four parts in order: a run of zero cells, a fixed synchronisation word, a set number of 16-bit data words, and then zero cells until the next sector mark.

Each 20-cell word carries its 16 data bits least significant first. Four check cells follow, and these are computed so that the word's count of one cells is a multiple of four. The data words are fetched from memory one word ahead. A single-cycle request is issued in the cycle in which the 17th cell of the synchronisation word or of a data word begins. A fetch that has not arrived when its word must start is replaced by zero, and a sticky underrun flag is set. The pulse line stays high until an index mark has been seen after reset, and whenever the enable input is low.

Top module: `sector_pulse_gen`

## Requirements
- R1: A bit cell lasts CELL_CYC cycles (default 70). The line is driven low for PULSE_CYC cycles (default 10) from the cell's first cycle. For a one cell, the line is also driven low for PULSE_CYC cycles starting HALF_CYC cycles (default 35) into the cell. At all other times the line is high.
- R2: After reset, `read_n` stays high and sector marks are ignored until `index_mark` has been sampled high at least once.
- R3: While `enable` is low, `read_n` is high and `word_cnt` is zero. Raising `enable` again resumes zero cells without a sector mark.
- R4: A falling edge of `sector_mark` restarts timing, so that the next cycle is cycle 0 of a cell. It is followed by PRE_CELLS zero cells (default 179, about 250 µs).
- R5: The synchronisation word follows as the cells 0 (fifteen times), 1, 1, 1, 1, 0.
- R6: Then NWORDS data words are sent (default 321). Each is 20 cells, with the memory word's bit 0 first through bit 15.
- R7: Cells 16 to 19 of a word hold k ones followed by zeros, where k = (4 − popcount(data)) mod 4. This gives 0000, 1000, 1100 or 1110 in cell order.
- R8: `mem_req` is high for exactly one cycle, in the first cycle of cell 16 of the synchronisation word and of every data word except the last. `mem_idx` then equals the index of the next data word, counting from 0.
- R9: `word_cnt` is 0 from the cycle after the sector mark edge. It increases by one at the start of each data word and ends at NWORDS.
- R10: After the last data word, zero cells continue until the next falling edge of `sector_mark`.
- R11: A data word whose fetch has not been accepted (`mem_valid` with the pending request) by its start is sent as zero data, with check cells 0000. `underrun` then goes high and stays high until reset. A response that arrives late is discarded.
- R12: During and just after reset, `read_n` is 1 and `mem_req`, `word_cnt` and `underrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Generation enable |
| index_mark | input | 1 | Index mark; the first high sample arms the block |
| sector_mark | input | 1 | Sector mark; its falling edge starts a sector |
| mem_data | input | 16 | Word returned from memory |
| mem_valid | input | 1 | One-cycle strobe for `mem_data` |
| read_n | output | 1 | Active-low read pulse line |
| mem_req | output | 1 | One-cycle memory read request |
| mem_idx | output | $clog2(NWORDS) | Word index of the request |
| word_cnt | output | $clog2(NWORDS+1) | Data words started in this sector |
| underrun | output | 1 | Sticky: a word was sent as zero for lack of data |

## Verification
The bench checks the pulse line cycle by cycle against an expected cell queue. This catches a design that drifts by one cycle at the sector edge, that sends bits most significant first, or that sets the check cells in the wrong order. Its data words are chosen so that all four check patterns occur, including all-ones and all-zeros words, so a wrong modulo or a pattern aligned the wrong way fails at once. A responder that withholds one fetch exposes a design that reuses a stale word instead of sending zero, or that lets the flag clear. Sector marks sent before the index and while `enable` is low catch a design that starts generating too early or keeps running while disabled.

// File: rtl/spg_pkg.sv
// Shared constants, sequencer states and the check-cell encoder for the
// sector read pulse generator. Assumes 16-bit data words and 20-cell words.
package spg_pkg;

    localparam int DATA_BITS      = 16;
    localparam int CELLS_PER_WORD = 20;
    localparam logic [DATA_BITS-1:0] SYNC_VALUE = 16'h8000;

    typedef enum logic [2:0] {
        ST_OFF,    // generation disabled
        ST_GAP,    // zero cells, waiting for a sector mark
        ST_PRE,    // zero preamble after the sector mark
        ST_SYNC,   // synchronisation word
        ST_WORD    // data word
    } seq_state_t;

    // Build the 20 cells of a word, cell 0 in bit 0: data low bit first,
    // then leading-ones check cells that round the one count up to 4n.
    function automatic logic [CELLS_PER_WORD-1:0] word_cells(input logic [DATA_BITS-1:0] d);
        logic [4:0] ones;
        logic [1:0] k;
        logic [3:0] chk;
        ones = '0;
        for (int i = 0; i < DATA_BITS; i++) begin
            ones = ones + {4'd0, d[i]};
        end
        k   = 2'(~ones[1:0] + 2'd1);
        chk = {1'b0, (k == 2'd3), (k >= 2'd2), (k >= 2'd1)};
        return {chk, d};
    endfunction

endpackage

// File: rtl/spg_cell_timer.sv
// Cell timer: counts the cycles of one bit cell and shapes the active-low
// pulse line from the current cell value. Assumes PULSE_CYC <= HALF_CYC and
// HALF_CYC + PULSE_CYC <= CELL_CYC. Held at cycle 0 while run is low.
module spg_cell_timer #(
    parameter int CELL_CYC  = 70,
    parameter int HALF_CYC  = 35,
    parameter int PULSE_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic cell_bit,
    output logic cell_last,
    output logic line_n
);

    localparam int CYC_W = $clog2(CELL_CYC);
    localparam logic [CYC_W-1:0] LAST_C  = CYC_W'(CELL_CYC - 1);
    localparam logic [CYC_W-1:0] PULSE_C = CYC_W'(PULSE_CYC);
    localparam logic [CYC_W-1:0] HALF_C  = CYC_W'(HALF_CYC);
    localparam logic [CYC_W-1:0] DEND_C  = CYC_W'(HALF_CYC + PULSE_CYC);

    logic [CYC_W-1:0] cyc;
    logic clk_pulse, data_pulse;

    // Cycle-in-cell counter, restarted by a sector mark edge.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart || cyc == LAST_C) begin
            cyc <= '0;
        end else begin
            cyc <= cyc + 1'b1;
        end
    end

    // Pulse shaping: clock pulse at cell start, data pulse at mid-cell.
    always_comb begin
        clk_pulse  = (cyc < PULSE_C);
        data_pulse = cell_bit && (cyc >= HALF_C) && (cyc < DEND_C);
        line_n     = !(run && (clk_pulse || data_pulse));
        cell_last  = run && (cyc == LAST_C);
    end

endmodule

// File: rtl/spg_word_ser.sv
// Word serialiser: loads a 16-bit value as 20 encoded cells and presents
// one cell at a time on cell_bit, advancing on each shift strobe.
module spg_word_ser
    import spg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [DATA_BITS-1:0] load_val,
    input  logic                 shift,
    output logic                 cell_bit
);

    logic [CELLS_PER_WORD-1:0] cells;

    // Cell shift register, loaded by the word start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cells <= '0;
        end else if (load) begin
            cells <= word_cells(load_val);
        end else if (shift) begin
            cells <= cells >> 1;
        end
    end

    assign cell_bit = cells[0];

endmodule

// File: rtl/spg_sector_seq.sv
// Sector sequencer: walks preamble, sync word, data words and gap at cell
// boundaries, issues the word start pulse, prefetches memory words one word
// ahead and substitutes zero when a fetch is late. Assumes the memory
// returns at most one mem_valid per request.
module spg_sector_seq
    import spg_pkg::*;
#(
    parameter int PRE_CELLS = 179,
    parameter int NWORDS    = 321,
    parameter int IDX_W     = $clog2(NWORDS),
    parameter int WC_W      = $clog2(NWORDS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 active,
    input  logic                 sector_mark,
    input  logic                 cell_last,
    input  logic [DATA_BITS-1:0] mem_data,
    input  logic                 mem_valid,
    output logic                 restart,
    output logic                 in_word,
    output logic                 word_start,
    output logic [DATA_BITS-1:0] word_val,
    output logic                 word_shift,
    output logic                 mem_req,
    output logic [IDX_W-1:0]     mem_idx,
    output logic [WC_W-1:0]      word_cnt,
    output logic                 underrun
);

    localparam int CNT_MAX = (PRE_CELLS > CELLS_PER_WORD) ? PRE_CELLS : CELLS_PER_WORD;
    localparam int CELL_W  = $clog2(CNT_MAX);
    localparam logic [CELL_W-1:0] PRE_LAST  = CELL_W'(PRE_CELLS - 1);
    localparam logic [CELL_W-1:0] WORD_LAST = CELL_W'(CELLS_PER_WORD - 1);
    localparam logic [CELL_W-1:0] REQ_CELL  = CELL_W'(DATA_BITS - 1);
    localparam logic [WC_W-1:0]   NW_C      = WC_W'(NWORDS);

    seq_state_t           state;
    logic [CELL_W-1:0]    cell_idx;
    logic                 sm_q;
    logic [DATA_BITS-1:0] buf_q;
    logic                 buf_full;
    logic                 pending;
    logic                 start_sync, word_done, start_data, req_now, more_words;

    // Boundary decode for the current cell.
    always_comb begin
        restart    = active && sm_q && !sector_mark;
        in_word    = (state == ST_SYNC) || (state == ST_WORD);
        more_words = (word_cnt < NW_C);
        start_sync = cell_last && !restart && (state == ST_PRE) && (cell_idx == PRE_LAST);
        word_done  = cell_last && !restart && in_word && (cell_idx == WORD_LAST);
        start_data = word_done && ((state == ST_SYNC) || more_words);
        req_now    = cell_last && !restart && in_word && (cell_idx == REQ_CELL) && more_words;
        word_start = start_sync || start_data;
        word_shift = cell_last && !restart && in_word && (cell_idx != WORD_LAST);
        word_val   = start_sync ? SYNC_VALUE : (buf_full ? buf_q : '0);
    end

    // Sector mark history for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sm_q <= 1'b0;
        end else begin
            sm_q <= sector_mark;
        end
    end

    // Sector state and cell index, advanced at cell boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            state    <= ST_OFF;
            cell_idx <= '0;
        end else if (restart) begin
            state    <= ST_PRE;
            cell_idx <= '0;
        end else if (state == ST_OFF) begin
            state    <= ST_GAP;
        end else if (cell_last) begin
            unique case (state)
                ST_PRE: begin
                    if (cell_idx == PRE_LAST) begin
                        state    <= ST_SYNC;
                        cell_idx <= '0;
                    end else begin
                        cell_idx <= cell_idx + 1'b1;
                    end
                end
                ST_SYNC, ST_WORD: begin
                    if (cell_idx == WORD_LAST) begin
                        state    <= start_data ? ST_WORD : ST_GAP;
                        cell_idx <= '0;
                    end else begin
                        cell_idx <= cell_idx + 1'b1;
                    end
                end
                default: cell_idx <= '0;
            endcase
        end
    end

    // Data word counter for the current sector.
    always_ff @(posedge clk) begin
        if (!rst_n || !active || restart) begin
            word_cnt <= '0;
        end else if (start_data) begin
            word_cnt <= word_cnt + 1'b1;
        end
    end

    // Prefetch request, one cycle wide, index of the next data word.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            mem_req <= 1'b0;
            mem_idx <= '0;
        end else begin
            mem_req <= req_now;
            if (req_now) begin
                mem_idx <= word_cnt[IDX_W-1:0];
            end
        end
    end

    // Prefetch buffer; a response is taken only while its request is open.
    always_ff @(posedge clk) begin
        if (!rst_n || !active || restart) begin
            buf_full <= 1'b0;
            pending  <= 1'b0;
            buf_q    <= '0;
        end else begin
            if (mem_req) begin
                pending <= 1'b1;
            end
            if (mem_valid && pending) begin
                buf_q    <= mem_data;
                buf_full <= 1'b1;
                pending  <= 1'b0;
            end
            if (start_data) begin
                buf_full <= 1'b0;
                pending  <= 1'b0;
            end
        end
    end

    // Sticky underrun flag, set when a data word starts without data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            underrun <= 1'b0;
        end else if (start_data && !buf_full) begin
            underrun <= 1'b1;
        end
    end

endmodule

// File: rtl/sector_pulse_gen.sv
// Top of the sector read pulse generator. Arms on the first index mark after
// reset, gates everything with enable, and ties the cell timer, the word
// serialiser and the sector sequencer together.
module sector_pulse_gen
    import spg_pkg::*;
#(
    parameter int CELL_CYC  = 70,
    parameter int HALF_CYC  = 35,
    parameter int PULSE_CYC = 10,
    parameter int PRE_CELLS = 179,
    parameter int NWORDS    = 321,
    localparam int IDX_W    = $clog2(NWORDS),
    localparam int WC_W     = $clog2(NWORDS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic                 index_mark,
    input  logic                 sector_mark,
    input  logic [DATA_BITS-1:0] mem_data,
    input  logic                 mem_valid,
    output logic                 read_n,
    output logic                 mem_req,
    output logic [IDX_W-1:0]     mem_idx,
    output logic [WC_W-1:0]      word_cnt,
    output logic                 underrun
);

    logic                 index_seen;
    logic                 active;
    logic                 restart, cell_last, in_word, ser_bit;
    logic                 word_start, word_shift;
    logic [DATA_BITS-1:0] word_val;

    // Arming flag: set by the first index mark sample after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            index_seen <= 1'b0;
        end else if (index_mark) begin
            index_seen <= 1'b1;
        end
    end

    assign active = index_seen && enable;

    spg_cell_timer #(
        .CELL_CYC (CELL_CYC),
        .HALF_CYC (HALF_CYC),
        .PULSE_CYC(PULSE_CYC)
    ) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (active),
        .restart  (restart),
        .cell_bit (in_word && ser_bit),
        .cell_last(cell_last),
        .line_n   (read_n)
    );

    spg_word_ser ser_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (word_start),
        .load_val(word_val),
        .shift   (word_shift),
        .cell_bit(ser_bit)
    );

    spg_sector_seq #(
        .PRE_CELLS(PRE_CELLS),
        .NWORDS   (NWORDS),
        .IDX_W    (IDX_W),
        .WC_W     (WC_W)
    ) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (active),
        .sector_mark(sector_mark),
        .cell_last  (cell_last),
        .mem_data   (mem_data),
        .mem_valid  (mem_valid),
        .restart    (restart),
        .in_word    (in_word),
        .word_start (word_start),
        .word_val   (word_val),
        .word_shift (word_shift),
        .mem_req    (mem_req),
        .mem_idx    (mem_idx),
        .word_cnt   (word_cnt),
        .underrun   (underrun)
    );

endmodule

// File: rtl/sector_pulse_gen_chk.sv
// Property checker for sector_pulse_gen, attached with bind below.
module sector_pulse_gen_chk #(
    parameter int NWORDS = 321,
    parameter int IDX_W  = $clog2(NWORDS),
    parameter int WC_W   = $clog2(NWORDS + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             index_seen,
    input logic             read_n,
    input logic             mem_req,
    input logic [IDX_W-1:0] mem_idx,
    input logic [WC_W-1:0]  word_cnt,
    input logic             underrun
);

    // R1: a pulse lasts more than one cycle unless generation stops.
    p_pulse_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(read_n) |=> (!read_n || !enable));

    // R2: nothing on the line before the first index mark.
    p_no_cells_unarmed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !index_seen |-> read_n);

    // R3: disabled means an idle-high line.
    p_disabled_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> read_n);

    // R8: a request is a single-cycle strobe.
    p_req_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R8: the requested index is the count of data words already started.
    p_req_index_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (word_cnt == WC_W'(mem_idx)));

    // R9: the word counter never passes the sector length.
    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        word_cnt <= WC_W'(NWORDS));

    // R11: the underrun flag never clears on its own.
    p_underrun_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun);

endmodule

bind sector_pulse_gen sector_pulse_gen_chk #(
    .NWORDS(NWORDS),
    .IDX_W (IDX_W),
    .WC_W  (WC_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .index_seen(index_seen),
    .read_n    (read_n),
    .mem_req   (mem_req),
    .mem_idx   (mem_idx),
    .word_cnt  (word_cnt),
    .underrun  (underrun)
);

// File: tb/sector_pulse_gen_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the sector driver pushes expected cells and request
// indices into queues; a line monitor and a memory responder pop and compare.
module sector_pulse_gen_tb_top;

    localparam int CELL  = 14;
    localparam int HALF  = 7;
    localparam int PULSE = 3;
    localparam int PRE   = 4;
    localparam int NW    = 4;
    localparam int IW    = $clog2(NW);
    localparam int WW    = $clog2(NW + 1);
    localparam int PADN  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic          index_mark = 1'b0;
    logic          sector_mark = 1'b0;
    logic [15:0]   mem_data = '0;
    logic          mem_valid = 1'b0;
    logic          read_n, mem_req, underrun;
    logic [IW-1:0] mem_idx;
    logic [WW-1:0] word_cnt;

    always #2.5 clk = ~clk;

    sector_pulse_gen #(
        .CELL_CYC(CELL), .HALF_CYC(HALF), .PULSE_CYC(PULSE),
        .PRE_CELLS(PRE), .NWORDS(NW)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .index_mark(index_mark),
        .sector_mark(sector_mark), .mem_data(mem_data), .mem_valid(mem_valid),
        .read_n(read_n), .mem_req(mem_req), .mem_idx(mem_idx),
        .word_cnt(word_cnt), .underrun(underrun)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    bit    exp_cells[$];
    string exp_tag[$];
    int    exp_idx[$];
    logic [15:0] mem_model [NW];
    int    skip_idx = -1;
    bit    mon_busy = 1'b0;
    event  cell_sync;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic push_cell(input bit b, input string tag);
        exp_cells.push_back(b);
        exp_tag.push_back(tag);
    endtask

    // Expected cells of one word: data low bit first, then k leading ones.
    task automatic push_word(input logic [15:0] w, input string dtag, input string ctag);
        int k;
        k = (4 - ($countones(w) % 4)) % 4;
        for (int i = 0; i < 16; i++) push_cell(w[i], dtag);
        for (int j = 0; j < 4; j++) push_cell(j < k, ctag);
    endtask

    // Count low cycles of read_n over n cycles.
    task automatic count_low(input int n, output int lows);
        lows = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (read_n === 1'b0) lows++;
        end
    endtask

    // Monitor: compares the line with each expected cell, cycle by cycle.
    initial begin
        forever begin
            @(cell_sync);
            mon_busy = 1'b1;
            while (exp_cells.size() > 0) begin
                bit    b;
                string tag;
                int    bad;
                int    act;
                b   = exp_cells.pop_front();
                tag = exp_tag.pop_front();
                bad = -1;
                act = 0;
                for (int k = 0; k < CELL; k++) begin
                    logic el;
                    @(negedge clk);
                    el = !((k < PULSE) || (b && k >= HALF && k < HALF + PULSE));
                    if (read_n !== el && bad < 0) begin
                        bad = k;
                        act = read_n;
                    end
                end
                check(bad < 0, tag, $sformatf("cell value %0d, line at cycle %0d", b, bad),
                      act, 1 - act);
            end
            mon_busy = 1'b0;
        end
    end

    // Memory responder: checks each request index and answers after 4 cycles.
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req === 1'b1) begin
                int e;
                int idx;
                e   = (exp_idx.size() > 0) ? exp_idx[0] : -1;
                idx = int'(mem_idx);
                check(idx == e, "R8", "request index", idx, e);
                if (exp_idx.size() > 0) void'(exp_idx.pop_front());
                if (idx != skip_idx) begin
                    repeat (4) @(negedge clk);
                    mem_data  = mem_model[idx];
                    mem_valid = 1'b1;
                    @(negedge clk);
                    mem_valid = 1'b0;
                end
            end
        end
    end

    // Driver: queues the expected sector, then makes the sector mark edge.
    task automatic run_sector(input bit exp_underrun);
        for (int i = 0; i < PRE; i++) push_cell(1'b0, "R4");
        push_word(16'h8000, "R5", "R5");
        for (int w = 0; w < NW; w++) begin
            if (w == skip_idx) push_word(16'h0000, "R11", "R11");
            else               push_word(mem_model[w], "R6", "R7");
            exp_idx.push_back(w);
        end
        for (int i = 0; i < PADN; i++) push_cell(1'b0, "R10");
        @(negedge clk);
        sector_mark = 1'b1;
        repeat (3) @(negedge clk);
        sector_mark = 1'b0;
        @(posedge clk);
        ->cell_sync;
        @(negedge clk);
        check(word_cnt == 0, "R9", "word count at sector start", word_cnt, 0);
        while (exp_cells.size() != 0 || mon_busy) @(negedge clk);
        check(word_cnt == NW, "R9", "word count at sector end", word_cnt, NW);
        check(exp_idx.size() == 0, "R8", "requests missing", exp_idx.size(), 0);
        check(underrun == exp_underrun, "R11", "underrun flag", underrun, exp_underrun);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        int lows;
        repeat (5) @(negedge clk);
        check(read_n === 1'b1, "R12", "line in reset", read_n, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(read_n === 1'b1 && mem_req === 1'b0, "R12", "line/request after reset",
              {read_n, mem_req}, 2);
        check(word_cnt == 0 && underrun === 1'b0, "R12", "count/flag after reset",
              {word_cnt, underrun}, 0);

        // R2: sector marks before the index mark are ignored.
        enable = 1'b1;
        sector_mark = 1'b1;
        repeat (3) @(negedge clk);
        sector_mark = 1'b0;
        count_low(3 * CELL, lows);
        check(lows == 0, "R2", "low cycles before index", lows, 0);
        check(word_cnt == 0, "R2", "word count before index", word_cnt, 0);

        // R1: after the index, free-running zero cells carry one pulse each.
        index_mark = 1'b1;
        @(negedge clk);
        index_mark = 1'b0;
        repeat (2) @(negedge clk);
        count_low(2 * CELL, lows);
        check(lows == 2 * PULSE, "R1", "low cycles in two zero cells", lows, 2 * PULSE);

        // Sector 1: check patterns 1100, 0000, 1110, 1000.
        mem_model[0] = 16'h0005; mem_model[1] = 16'hFFFF;
        mem_model[2] = 16'h0001; mem_model[3] = 16'h8003;
        run_sector(1'b0);

        // Sector 2: other patterns including an all-zero word.
        mem_model[0] = 16'hA5A5; mem_model[1] = 16'h1234;
        mem_model[2] = 16'h0000; mem_model[3] = 16'h7FFF;
        run_sector(1'b0);

        // Sector 3: the fetch for word 2 never answers (R11).
        mem_model[0] = 16'h00F0; mem_model[1] = 16'h0303;
        mem_model[2] = 16'hFFFF; mem_model[3] = 16'h4001;
        skip_idx = 2;
        run_sector(1'b1);
        skip_idx = -1;

        // R3: disabling forces the line high and clears the word count.
        enable = 1'b0;
        @(negedge clk);
        count_low(2 * CELL, lows);
        check(lows == 0, "R3", "low cycles while disabled", lows, 0);
        check(word_cnt == 0, "R3", "word count while disabled", word_cnt, 0);
        check(underrun === 1'b1, "R11", "flag kept while disabled", underrun, 1);
        enable = 1'b1;
        repeat (2) @(negedge clk);
        count_low(2 * CELL, lows);
        check(lows == 2 * PULSE, "R3", "zero cells after re-enable", lows, 2 * PULSE);

        // R10/R8: long gap stays zero cells with no requests.
        count_low(4 * CELL, lows);
        check(lows == 4 * PULSE, "R10", "gap low cycles", lows, 4 * PULSE);
        check(exp_idx.size() == 0, "R8", "no stray requests", exp_idx.size(), 0);

        finish_up();
    end

endmodule